// File: doc/BRIEF.md
# Speculative Cache/TCM Read Steering

This block sits on one side (instruction or data) of a level-one memory system and decides, for each read, which of two RAMs to wake: the tightly coupled memory (TCM) or the cache data RAM. To save power only one RAM is enabled per access. The choice is a guess: the RAM that served the previous access on this side. The address decode against the programmable TCM window is registered and compared with the guess one cycle later, when the speculative read data is already back. A correct guess returns data one cycle after the request. A wrong guess makes the block stall the requester, reissue the same address to the other RAM, and return that data, so the access takes three cycles in total.

A request carries an address and a sequential flag. A sequential access keeps the target of the access before it and skips the window decode, so it never mispredicts. The TCM window is a naturally aligned power-of-two region described by a base address and a size exponent. An address inside the window is served by the TCM even when the cache tag logic also reports a hit. The cache hit flag comes from outside, and tag lookup, the RAM arrays and level-two handling are not part of this block.

Top module: `l1_read_steer`

## Requirements
- R1: While reset is asserted, both chip-enables, `rsp_valid` and `req_stall` are low. After reset the prediction is the cache, so the first non-sequential access to a cache address completes without a stall.
- R2: In no cycle are `tcm_ce` and `cache_ce` high together.
- R3: An accepted request whose guess is right enables the guessed RAM in the request cycle with `ram_addr` equal to the request address. In the next cycle `rsp_valid` is high, `req_stall` is low and `rsp_data` is that RAM's read data.
- R4: The guess for an accepted request is the target of the previous accepted request on this side, or the cache if none has been accepted since reset.
- R5: A non-sequential address belongs to the TCM when `(req_addr & ~(2**cfg_tcm_log2 - 1)) == cfg_tcm_base`, and otherwise to the cache. For a TCM address, `rsp_data` comes from the TCM and `rsp_hit` is high whatever `cache_hit` says.
- R6: A sequential request (`req_seq`=1) takes the target of the previous accepted request, ignores the window decode, and never causes a stall.
- R7: When an accepted request at cycle N mispredicts, `req_stall` is high in N+1 and N+2. In N+1 only the correct RAM is enabled, with the same address. In N+2 `rsp_valid` is high with the correct RAM's data. The next request can be accepted at N+3.
- R8: A request presented while `req_stall` is high is ignored. It enables no RAM, gets no response, and does not change the prediction.
- R9: With `rsp_valid` high, `rsp_from_tcm` is 1 for a TCM target and 0 for a cache target. `rsp_hit` is `rsp_from_tcm` OR `cache_hit` as sampled in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tcm_base | input | ADDR_W | Aligned base address of the TCM window |
| cfg_tcm_log2 | input | LOG_W | log2 of the TCM window size in bytes |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Request address |
| req_seq | input | 1 | Request continues the previous access sequentially |
| req_stall | output | 1 | Requester must hold off; requests are ignored |
| tcm_ce | output | 1 | TCM RAM read enable |
| cache_ce | output | 1 | Cache data RAM read enable |
| ram_addr | output | ADDR_W | Address presented to the enabled RAM |
| tcm_rdata | input | DATA_W | TCM read data, one cycle after `tcm_ce` |
| cache_rdata | input | DATA_W | Cache read data, one cycle after `cache_ce` |
| cache_hit | input | 1 | Cache tag hit, aligned with `cache_rdata` |
| rsp_valid | output | 1 | Response data valid |
| rsp_data | output | DATA_W | Response read data |
| rsp_hit | output | 1 | Level-one hit for the response |
| rsp_from_tcm | output | 1 | Response was served by the TCM |

## Verification
The bound checker checks every cycle that the chip-enables are mutually exclusive, that a stall always lasts exactly two cycles, and that its first cycle re-reads the same address from the other RAM. It also checks that the second stall cycle carries the response with no RAM enabled, that a sequential request never starts a stall, and that a TCM response always reports a hit. Which RAM the prediction picks, the window decode at its edges, the TCM-over-cache priority and the returned data depend on the history of accesses and on the configured window. Only the bench's reference model shows these, across directed boundary cases and random request streams that mix sequential, in-window and out-of-window accesses with requests held during stalls.

// File: rtl/l1s_pkg.sv
package l1s_pkg;

   // Which level-one RAM serves (or is guessed to serve) an access.
   typedef enum logic {
      TGT_CACHE = 1'b0,
      TGT_TCM   = 1'b1
   } tgt_e;

endpackage

// File: rtl/l1s_region_match.sv
// Decides whether an address falls in the naturally aligned TCM window.
module l1s_region_match #(
   parameter int ADDR_W = 32,
   parameter int LOG_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [LOG_W-1:0]  size_log2,
   output logic              in_window
);

   logic [ADDR_W-1:0] keep_mask;

   // Bit i survives the mask when it lies at or above the window size exponent.
   for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
      assign keep_mask[i] = (size_log2 <= LOG_W'(i));
   end

   assign in_window = ((addr & keep_mask) == base);

endmodule

// File: rtl/l1s_target_pred.sv
// Holds the last served target; produces the guess and the resolved target.
module l1s_target_pred
   import l1s_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic req_seq,
   input  logic in_window,
   output tgt_e guess,
   output tgt_e resolved
);

   tgt_e last_q;

   assign guess    = last_q;
   assign resolved = req_seq ? last_q : (in_window ? TGT_TCM : TGT_CACHE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= TGT_CACHE;
      end else if (accept) begin
         last_q <= resolved;
      end
   end

endmodule

// File: rtl/l1s_access_seq.sv
// Issues the speculative read, checks the guess one cycle later and replays.
module l1s_access_seq
   import l1s_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  tgt_e              guess,
   input  tgt_e              resolved,
   output logic              accept,
   output logic              stall,
   output logic              tcm_ce,
   output logic              cache_ce,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              rsp_valid,
   output tgt_e              rsp_tgt
);

   logic              look_q;     // a speculative read is returning this cycle
   logic              replay_q;   // the replayed read is returning this cycle
   tgt_e              look_guess_q;
   tgt_e              look_tgt_q;
   logic [ADDR_W-1:0] look_addr_q;
   logic              wrong;

   assign wrong     = look_q && (look_guess_q != look_tgt_q);
   assign stall     = wrong || replay_q;
   assign accept    = rst_n && req_valid && !stall;
   assign rsp_valid = (look_q && !wrong) || replay_q;
   assign rsp_tgt   = look_tgt_q;

   always_comb begin
      tcm_ce   = 1'b0;
      cache_ce = 1'b0;
      ram_addr = req_addr;
      if (wrong) begin
         ram_addr = look_addr_q;
         tcm_ce   = (look_tgt_q == TGT_TCM);
         cache_ce = (look_tgt_q == TGT_CACHE);
      end else if (accept) begin
         tcm_ce   = (guess == TGT_TCM);
         cache_ce = (guess == TGT_CACHE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         look_q       <= 1'b0;
         replay_q     <= 1'b0;
         look_guess_q <= TGT_CACHE;
         look_tgt_q   <= TGT_CACHE;
         look_addr_q  <= '0;
      end else begin
         look_q   <= accept;
         replay_q <= wrong;
         if (accept) begin
            look_guess_q <= guess;
            look_tgt_q   <= resolved;
            look_addr_q  <= req_addr;
         end
      end
   end

endmodule

// File: rtl/l1s_rsp_sel.sv
// Picks the returning RAM's data and forms the hit flag.
module l1s_rsp_sel
   import l1s_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  tgt_e              rsp_tgt,
   input  logic [DATA_W-1:0] tcm_rdata,
   input  logic [DATA_W-1:0] cache_rdata,
   input  logic              cache_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_hit,
   output logic              rsp_from_tcm
);

   assign rsp_from_tcm = (rsp_tgt == TGT_TCM);
   assign rsp_data     = rsp_from_tcm ? tcm_rdata : cache_rdata;
   assign rsp_hit      = rsp_from_tcm | cache_hit;

endmodule

// File: rtl/l1_read_steer.sv
module l1_read_steer
   import l1s_pkg::*;
#(
   parameter  int ADDR_W = 32,
   parameter  int DATA_W = 32,
   localparam int LOG_W  = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_tcm_base,
   input  logic [LOG_W-1:0]  cfg_tcm_log2,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_seq,
   output logic              req_stall,
   output logic              tcm_ce,
   output logic              cache_ce,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [DATA_W-1:0] tcm_rdata,
   input  logic [DATA_W-1:0] cache_rdata,
   input  logic              cache_hit,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_hit,
   output logic              rsp_from_tcm
);

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("l1_read_steer: ADDR_W must lie in 8..64");
   end
   if (DATA_W < 8) begin : g_bad_data_w
      $error("l1_read_steer: DATA_W must be at least 8");
   end

   logic in_window;
   logic accept;
   tgt_e guess;
   tgt_e resolved;
   tgt_e rsp_tgt;

   l1s_region_match #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_region (
      .addr      (req_addr),
      .base      (cfg_tcm_base),
      .size_log2 (cfg_tcm_log2),
      .in_window (in_window)
   );

   l1s_target_pred u_pred (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_seq   (req_seq),
      .in_window (in_window),
      .guess     (guess),
      .resolved  (resolved)
   );

   l1s_access_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .guess     (guess),
      .resolved  (resolved),
      .accept    (accept),
      .stall     (req_stall),
      .tcm_ce    (tcm_ce),
      .cache_ce  (cache_ce),
      .ram_addr  (ram_addr),
      .rsp_valid (rsp_valid),
      .rsp_tgt   (rsp_tgt)
   );

   l1s_rsp_sel #(.DATA_W(DATA_W)) u_rsp (
      .rsp_tgt      (rsp_tgt),
      .tcm_rdata    (tcm_rdata),
      .cache_rdata  (cache_rdata),
      .cache_hit    (cache_hit),
      .rsp_data     (rsp_data),
      .rsp_hit      (rsp_hit),
      .rsp_from_tcm (rsp_from_tcm)
   );

endmodule

// File: rtl/l1s_steer_chk.sv
module l1s_steer_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_seq,
   input logic              req_stall,
   input logic              tcm_ce,
   input logic              cache_ce,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_from_tcm
);

   // R1: quiet while reset is held
   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |-> (!tcm_ce && !cache_ce && !rsp_valid && !req_stall));

   // R2: never both RAMs at once
   a_r2_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tcm_ce, cache_ce}));

   // R3: an accepted request is answered next cycle unless a replay starts
   a_r3_next_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_stall) |=> (rsp_valid || req_stall));

   // R6: sequential requests never start a stall
   a_r6_seq_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_stall && req_seq) |=> !req_stall);

   // R7: first stall cycle re-reads the same address from the other RAM
   a_r7_replay_other_ram: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_stall) |-> ((ram_addr == $past(ram_addr)) &&
                            (tcm_ce == $past(cache_ce)) &&
                            (cache_ce == $past(tcm_ce))));

   // R7: a stall lasts two cycles
   a_r7_stall_second: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_stall) |=> req_stall);

   a_r7_stall_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (req_stall && $past(req_stall)) |=> !req_stall);

   // R7 and R8: second stall cycle returns data and enables nothing
   a_r8_idle_rams_in_return: assert property (@(posedge clk) disable iff (!rst_n)
      (req_stall && $past(req_stall)) |-> (rsp_valid && !tcm_ce && !cache_ce));

   // R9: a TCM response is always a hit
   a_r9_tcm_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_from_tcm) |-> rsp_hit);

endmodule

bind l1_read_steer l1s_steer_chk #(.ADDR_W(ADDR_W)) u_steer_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_seq      (req_seq),
   .req_stall    (req_stall),
   .tcm_ce       (tcm_ce),
   .cache_ce     (cache_ce),
   .ram_addr     (ram_addr),
   .rsp_valid    (rsp_valid),
   .rsp_hit      (rsp_hit),
   .rsp_from_tcm (rsp_from_tcm)
);

// File: tb/l1_read_steer_tb_top.sv
module l1_read_steer_tb_top;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_base = 32'h0001_0000;
   logic [LW-1:0] cfg_log2 = 6'd12;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_seq = 1'b0;
   logic          req_stall;
   logic          tcm_ce, cache_ce;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] tcm_rdata = '0;
   logic [DW-1:0] cache_rdata = '0;
   logic          cache_hit = 1'b0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          rsp_hit, rsp_from_tcm;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   l1_read_steer #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_tcm_base(cfg_base), .cfg_tcm_log2(cfg_log2),
      .req_valid(req_valid), .req_addr(req_addr), .req_seq(req_seq),
      .req_stall(req_stall), .tcm_ce(tcm_ce), .cache_ce(cache_ce), .ram_addr(ram_addr),
      .tcm_rdata(tcm_rdata), .cache_rdata(cache_rdata), .cache_hit(cache_hit),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
      .rsp_from_tcm(rsp_from_tcm)
   );

   function automatic logic [DW-1:0] tcm_word(input logic [AW-1:0] a);
      return a ^ 32'h5A00_00F0;
   endfunction
   function automatic logic [DW-1:0] cache_word(input logic [AW-1:0] a);
      return a ^ 32'h0C3C_9000;
   endfunction
   function automatic bit hit_of(input logic [AW-1:0] a);
      return a[3];
   endfunction
   function automatic bit in_tcm(input logic [AW-1:0] a);
      logic [AW-1:0] m;
      m = ~((32'h1 << cfg_log2) - 32'h1);
      return (a & m) == cfg_base;
   endfunction

   // Synchronous RAM models, one cycle read latency.
   always @(posedge clk) begin
      if (tcm_ce) tcm_rdata <= tcm_word(ram_addr);
      if (cache_ce) begin
         cache_rdata <= cache_word(ram_addr);
         cache_hit   <= hit_of(ram_addr);
      end
   end

   // Reference model state: schedule ring indexed by cycle.
   bit            m_last = 1'b0;     // 1 = TCM
   bit            s_stall [4];
   bit            s_rep   [4];
   bit            s_rep_t [4];
   logic [AW-1:0] s_rep_a [4];
   bit            s_rsp   [4];
   bit            s_rsp_t [4];
   logic [AW-1:0] s_rsp_a [4];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step(input bit v, input logic [AW-1:0] a, input bit seq);
      int  i, i1, i2;
      bit  acc, tgt, exp_t, exp_c;
      logic [AW-1:0] exp_a;
      string ce_req;
      @(negedge clk);
      req_valid = v; req_addr = a; req_seq = seq;
      #1;
      i = cyc % 4; i1 = (cyc + 1) % 4; i2 = (cyc + 2) % 4;
      acc = v && !s_stall[i];
      exp_t = 1'b0; exp_c = 1'b0; exp_a = a; ce_req = "R8";
      if (s_rep[i]) begin
         exp_t = s_rep_t[i]; exp_c = !s_rep_t[i]; exp_a = s_rep_a[i]; ce_req = "R7";
      end else if (acc) begin
         exp_t = m_last; exp_c = !m_last;
         ce_req = seq ? "R6" : "R4";
      end
      chk("R7", req_stall, s_stall[i]);
      chk("R2", tcm_ce && cache_ce, 1'b0);
      chk(ce_req, {tcm_ce, cache_ce}, {exp_t, exp_c});
      if (exp_t || exp_c) chk("R3", ram_addr, exp_a);
      chk("R3", rsp_valid, s_rsp[i]);
      if (s_rsp[i]) begin
         chk((s_rsp_t[i] && hit_of(s_rsp_a[i])) ? "R5" : "R3", rsp_data,
             s_rsp_t[i] ? tcm_word(s_rsp_a[i]) : cache_word(s_rsp_a[i]));
         chk("R9", rsp_from_tcm, s_rsp_t[i]);
         chk("R9", rsp_hit, s_rsp_t[i] || hit_of(s_rsp_a[i]));
      end
      s_stall[i] = 1'b0; s_rep[i] = 1'b0; s_rsp[i] = 1'b0;
      if (acc) begin
         tgt = seq ? m_last : in_tcm(a);
         if (tgt == m_last) begin
            s_rsp[i1] = 1'b1; s_rsp_t[i1] = tgt; s_rsp_a[i1] = a;
         end else begin
            s_stall[i1] = 1'b1; s_stall[i2] = 1'b1;
            s_rep[i1] = 1'b1; s_rep_t[i1] = tgt; s_rep_a[i1] = a;
            s_rsp[i2] = 1'b1; s_rsp_t[i2] = tgt; s_rsp_a[i2] = a;
         end
         m_last = tgt;
      end
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, '0, 1'b0);
   endtask

   function automatic logic [AW-1:0] rand_in();
      return (cfg_base | ($urandom & ((32'h1 << cfg_log2) - 1))) & ~32'h3;
   endfunction
   function automatic logic [AW-1:0] rand_out();
      return (cfg_base ^ (32'h1 << (cfg_log2 + ($urandom % 4)))) | ($urandom & 32'hFFC);
   endfunction

   initial begin
      logic [AW-1:0] prev;
      void'($urandom(32'd2718));
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk("R1", {req_stall, tcm_ce, cache_ce, rsp_valid}, 4'b0000);
      end
      @(negedge clk); rst_n = 1'b1;
      // R1, R4: first cache access after reset is guessed right
      step(1'b1, 32'h0000_4008, 1'b0);
      step(1'b1, 32'h0000_4010, 1'b0);
      // R7, R8: TCM access mispredicts; requests held during the stall are ignored
      step(1'b1, 32'h0001_0020, 1'b0);
      step(1'b1, 32'h0000_5000, 1'b0);
      step(1'b1, 32'h0000_5004, 1'b1);
      // R4: back-to-back TCM accesses after the switch
      step(1'b1, 32'h0001_0024, 1'b0);
      step(1'b1, 32'h0001_0028, 1'b0);
      // R6: sequential access outside the window stays on the TCM
      step(1'b1, 32'h0002_0000, 1'b1);
      // R5: TCM address that the cache also reports as a hit
      step(1'b1, 32'h0001_0ff8, 1'b0);
      // R7: switch back to the cache
      step(1'b1, 32'h0003_0008, 1'b0);
      idle(3);
      // R5: window edges with a small window
      cfg_base = 32'h0002_0100; cfg_log2 = 6'd8;
      step(1'b1, 32'h0002_00fc, 1'b0);
      step(1'b1, 32'h0002_0100, 1'b0);
      idle(2);
      step(1'b1, 32'h0002_01fc, 1'b0);
      step(1'b1, 32'h0002_0200, 1'b0);
      idle(3);
      // Random mix
      cfg_base = 32'h0040_0000; cfg_log2 = 6'd14;
      prev = 32'h0;
      for (int k = 0; k < 4000; k++) begin
         bit v, sq;
         logic [AW-1:0] a;
         v  = ($urandom % 10) < 7;
         sq = ($urandom % 4) == 0;
         a  = sq ? prev + 32'h4 : ((($urandom % 2) == 0) ? rand_in() : rand_out());
         step(v, a, sq);
         if (v) prev = a;
      end
      idle(4);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule